// File: doc/BRIEF.md
# DCT Block Statistics Analyzer

This block takes a stream of signed transform coefficients, 64 per 8x8 block with the positions of a block in raster order, and gathers three figures over a frame of N blocks. The figures are the average of the DC terms, the average of the 63 AC terms of each block, and the spread (variance) of those AC terms. A frame opens with a frame-start pulse that also samples N. Each block is marked by a block-start flag on its first coefficient. When the last coefficient of block N has been taken, the block divides its running sums with bit-serial dividers and presents the three results with a one-cycle valid strobe.

The variance is formed as the mean of the squares minus the square of the mean. A sum accumulator and a sum-of-squares accumulator run side by side. They are sized so that a full frame of the largest block count, with every coefficient at its extreme value, cannot overflow. Producing the coefficients and acting on the statistics are the job of neighbouring logic.

Top module: `dct_stats_unit`

## Requirements
- R1: After reset `statsValid` is 0 and `dcMean`, `acMean` and `acVar` are all 0. Coefficients presented before the first `frameStart` are ignored.
- R2: Position 0 of a block goes only to the DC sum. Positions 1 to 63 go only to the AC sums. Position 0 is the coefficient taken with `blockStart` or `frameStart` high, or the one taken after the 64th coefficient of the previous block.
- R3: `dcMean` equals the DC sum divided by N, truncated toward zero, as a 12-bit two's complement value.
- R4: `acMean` equals the AC sum divided by 63*N, truncated toward zero, as a 12-bit two's complement value.
- R5: `acVar` equals floor(sum of AC squares / (63*N)) minus `acMean` squared, as a 24-bit unsigned value.
- R6: A cycle with `inValid` low adds nothing to any sum and does not advance the position, whatever `coefIn` and `blockStart` carry.
- R7: `statsValid` is high for exactly one cycle per completed frame. The three results hold their values until the next strobe.
- R8: `frameStart` clears all sums and the block count, and samples `numBlocks` (valid range 1 to 4096). Later changes of `numBlocks` have no effect on that frame. A coefficient taken with `frameStart` high is the first coefficient (position 0) of the new frame.
- R9: Coefficients that arrive after the last block of a frame, while the results are being computed or while the block waits for the next `frameStart`, are ignored.
- R10: `blockStart` with `inValid` high forces the position back to 0 mid-block. Coefficients already taken stay in the sums, and the partial block is not counted.
- R11: The sums do not overflow for N = 4096 with every coefficient at -2048 or +2047. A frame of constant coefficients gives a mean equal to that constant and a variance of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frameStart | input | 1 | Opens a frame, clears the sums, samples numBlocks |
| numBlocks | input | 13 | Number of blocks N in the frame, 1 to 4096 |
| blockStart | input | 1 | Marks the coefficient at position 0 of a block |
| inValid | input | 1 | coefIn carries a coefficient this cycle |
| coefIn | input | 12 | Signed coefficient |
| statsValid | output | 1 | One-cycle strobe, results are fresh |
| dcMean | output | 12 | Signed mean of the DC terms |
| acMean | output | 12 | Signed mean of the AC terms |
| acVar | output | 24 | Variance of the AC terms |

## Verification
On every cycle, the embedded properties watch several things. An AC coefficient never moves the DC sum, and a DC coefficient never moves the AC sums. The sum of squares only grows between clears. The block count stays below the sampled N while a frame runs, and no block is counted outside a frame. They also check that the strobe lasts one cycle, that the results stay still between strobes, and that each divider's remainder stays below its divisor. The arithmetic values themselves, the truncation toward zero of negative means, the realignment by `blockStart`, and the frames at the largest magnitudes can only be shown by the bench's scenarios. Those scenarios compare against sums the bench builds from the stimulus it sends.

// File: rtl/dct_stats_pkg.sv
package dct_stats_pkg;

  // strobes from the sequencer to the arithmetic side
  typedef struct packed {
    logic clrAcc;    // start a fresh frame: sums restart from the current sample
    logic accEn;     // a coefficient is taken this cycle
    logic isDc;      // the taken coefficient sits at block position 0
    logic startDiv;  // load all dividers
    logic finish;    // dividers idle: register the results
  } ctrl_t;

endpackage

// File: rtl/dct_stats_div.sv
// Bit-serial restoring divider, unsigned, one quotient bit per cycle.
module dct_stats_div #(
  parameter int DIVD_W = 25,
  parameter int DIVS_W = 13,
  parameter int OUT_W  = 12,
  localparam int CNT_W = $clog2(DIVD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DIVD_W-1:0] dividend,
  input  logic [DIVS_W-1:0] divisor,
  output logic              busy,
  output logic [OUT_W-1:0]  quotient
);

  logic [DIVD_W-1:0] quo;
  logic [DIVS_W-1:0] rem, dv;
  logic [CNT_W-1:0]  cnt;
  logic [DIVS_W:0]   trial, remNext;
  logic              fits;

  always_comb begin
    trial   = {rem, quo[DIVD_W-1]};
    fits    = trial >= {1'b0, dv};
    remNext = fits ? (trial - {1'b0, dv}) : trial;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo  <= '0;
      rem  <= '0;
      dv   <= '0;
      cnt  <= '0;
      busy <= 1'b0;
    end else if (start) begin
      quo  <= dividend;
      rem  <= '0;
      dv   <= divisor;
      cnt  <= '0;
      busy <= 1'b1;
    end else if (busy) begin
      quo <= {quo[DIVD_W-2:0], fits};
      rem <= remNext[DIVS_W-1:0];
      cnt <= cnt + 1'b1;
      if (cnt == CNT_W'(DIVD_W - 1)) busy <= 1'b0;
    end
  end

  assign quotient = quo[OUT_W-1:0];

  // R3/R4/R5 depend on a well-formed division
  p_div_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> divisor != '0);
  p_rem_below_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> rem < dv);
  p_rem_fits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !remNext[DIVS_W]);

endmodule

// File: rtl/dct_stats_ctrl.sv
module dct_stats_ctrl
  import dct_stats_pkg::*;
#(
  parameter int COEF_PER_BLK = 64,
  parameter int NB_W         = 13,
  localparam int POS_W       = $clog2(COEF_PER_BLK)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frameStart,
  input  logic            blockStart,
  input  logic            inValid,
  input  logic [NB_W-1:0] numBlocks,
  input  logic            divIdle,
  output ctrl_t           ctl,
  output logic [NB_W-1:0] frameBlocks
);

  typedef enum logic [1:0] {S_IDLE, S_ACCUM, S_LAUNCH, S_WAIT} state_t;
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(COEF_PER_BLK - 1);

  state_t          state;
  logic [POS_W-1:0] pos, curPos;
  logic [NB_W-1:0]  blkCnt, nLatched, blkBase, blkNext, nEff;
  logic             take, lastCoef, frameEnd;

  always_comb begin
    curPos   = (blockStart || frameStart) ? '0 : pos;
    take     = inValid && (frameStart || state == S_ACCUM);
    lastCoef = take && (curPos == LAST_POS);
    blkBase  = frameStart ? '0 : blkCnt;
    blkNext  = blkBase + 1'b1;
    nEff     = frameStart ? numBlocks : nLatched;
    frameEnd = lastCoef && (blkNext == nEff);

    ctl.clrAcc   = frameStart;
    ctl.accEn    = take;
    ctl.isDc     = (curPos == '0);
    ctl.startDiv = (state == S_LAUNCH);
    ctl.finish   = (state == S_WAIT) && divIdle;
  end

  assign frameBlocks = blkCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      pos      <= '0;
      blkCnt   <= '0;
      nLatched <= '0;
    end else begin
      if (frameStart) begin
        nLatched <= numBlocks;
        pos      <= '0;
        blkCnt   <= '0;
        state    <= S_ACCUM;
      end
      if (take) begin
        pos <= lastCoef ? '0 : curPos + 1'b1;
        if (lastCoef) blkCnt <= blkNext;
      end
      if (frameEnd) begin
        state <= S_LAUNCH;
      end else if (!frameStart) begin
        case (state)
          S_LAUNCH: state <= S_WAIT;
          S_WAIT:   if (divIdle) state <= S_IDLE;
          default:  ;
        endcase
      end
    end
  end

  p_blk_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ACCUM) |-> (blkCnt < nLatched));
  p_realign_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (take && blockStart) |=> (pos == POS_W'(1)));
  p_outside_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((state != S_ACCUM) && !frameStart) |=> $stable(blkCnt));

endmodule

// File: rtl/dct_stats_dp.sv
module dct_stats_dp
  import dct_stats_pkg::*;
#(
  parameter int COEF_W     = 12,
  parameter int MAX_BLOCKS = 4096,
  parameter int AC_PER_BLK = 63,
  localparam int NB_W      = $clog2(MAX_BLOCKS + 1),
  localparam int ACCNT_W   = $clog2(AC_PER_BLK * MAX_BLOCKS + 1),
  localparam int DC_SUM_W  = COEF_W + NB_W,
  localparam int AC_SUM_W  = COEF_W + ACCNT_W,
  localparam int SQ_W      = 2 * COEF_W,
  localparam int SQ_SUM_W  = SQ_W + ACCNT_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  ctrl_t                    ctl,
  input  logic signed [COEF_W-1:0] coefIn,
  input  logic [NB_W-1:0]          frameBlocks,
  output logic                     divIdle,
  output logic                     statsValid,
  output logic signed [COEF_W-1:0] dcMean,
  output logic signed [COEF_W-1:0] acMean,
  output logic [SQ_W-1:0]          acVar
);

  logic signed [SQ_W-1:0]     prod;
  logic [SQ_W-1:0]            sqVal;
  logic signed [DC_SUM_W-1:0] dcSum, dcAdd;
  logic signed [AC_SUM_W-1:0] acSum, acAdd;
  logic [SQ_SUM_W-1:0]        sqSum, sqAdd;
  logic [DC_SUM_W-1:0]        dcMag;
  logic [AC_SUM_W-1:0]        acMag;
  logic [ACCNT_W-1:0]         acDen;
  logic [COEF_W-1:0]          dcQuo, acQuo;
  logic [SQ_W-1:0]            sqQuo, magSq, varNext;
  logic                       dcBusy, acBusy, sqBusy, dcNeg, acNeg;
  logic signed [COEF_W:0]     dcMeanW, acMeanW;

  function automatic logic signed [COEF_W:0] applySign(input logic neg,
                                                       input logic [COEF_W-1:0] mag);
    logic signed [COEF_W:0] wide;
    wide = $signed({1'b0, mag});
    return neg ? -wide : wide;
  endfunction

  // per-sample contributions, steered by block position
  always_comb begin
    prod  = coefIn * coefIn;
    sqVal = prod;
    dcAdd = (ctl.accEn && ctl.isDc)
          ? {{(DC_SUM_W-COEF_W){coefIn[COEF_W-1]}}, coefIn} : '0;
    acAdd = (ctl.accEn && !ctl.isDc)
          ? {{(AC_SUM_W-COEF_W){coefIn[COEF_W-1]}}, coefIn} : '0;
    sqAdd = (ctl.accEn && !ctl.isDc) ? {{(SQ_SUM_W-SQ_W){1'b0}}, sqVal} : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcSum <= '0;
      acSum <= '0;
      sqSum <= '0;
    end else begin
      dcSum <= (ctl.clrAcc ? '0 : dcSum) + dcAdd;
      acSum <= (ctl.clrAcc ? '0 : acSum) + acAdd;
      sqSum <= (ctl.clrAcc ? '0 : sqSum) + sqAdd;
    end
  end

  // magnitudes and signs for the unsigned dividers
  always_comb begin
    dcMag = dcSum[DC_SUM_W-1] ? -dcSum : dcSum;
    acMag = acSum[AC_SUM_W-1] ? -acSum : acSum;
    acDen = ACCNT_W'(frameBlocks) * ACCNT_W'(AC_PER_BLK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcNeg <= 1'b0;
      acNeg <= 1'b0;
    end else if (ctl.startDiv) begin
      dcNeg <= dcSum[DC_SUM_W-1];
      acNeg <= acSum[AC_SUM_W-1];
    end
  end

  dct_stats_div #(.DIVD_W(DC_SUM_W), .DIVS_W(NB_W), .OUT_W(COEF_W)) uDcDiv (
    .clk(clk), .rst_n(rst_n), .start(ctl.startDiv), .dividend(dcMag),
    .divisor(frameBlocks), .busy(dcBusy), .quotient(dcQuo));

  dct_stats_div #(.DIVD_W(AC_SUM_W), .DIVS_W(ACCNT_W), .OUT_W(COEF_W)) uAcDiv (
    .clk(clk), .rst_n(rst_n), .start(ctl.startDiv), .dividend(acMag),
    .divisor(acDen), .busy(acBusy), .quotient(acQuo));

  dct_stats_div #(.DIVD_W(SQ_SUM_W), .DIVS_W(ACCNT_W), .OUT_W(SQ_W)) uSqDiv (
    .clk(clk), .rst_n(rst_n), .start(ctl.startDiv), .dividend(sqSum),
    .divisor(acDen), .busy(sqBusy), .quotient(sqQuo));

  assign divIdle = !(dcBusy || acBusy || sqBusy);

  always_comb begin
    dcMeanW = applySign(dcNeg, dcQuo);
    acMeanW = applySign(acNeg, acQuo);
    magSq   = {{COEF_W{1'b0}}, acQuo} * {{COEF_W{1'b0}}, acQuo};
    varNext = sqQuo - magSq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      statsValid <= 1'b0;
      dcMean     <= '0;
      acMean     <= '0;
      acVar      <= '0;
    end else begin
      statsValid <= ctl.finish;
      if (ctl.finish) begin
        dcMean <= dcMeanW[COEF_W-1:0];
        acMean <= acMeanW[COEF_W-1:0];
        acVar  <= varNext;
      end
    end
  end

  p_ac_keeps_dc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.accEn && !ctl.isDc && !ctl.clrAcc) |=> dcSum == $past(dcSum));
  p_dc_keeps_ac_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.accEn && ctl.isDc && !ctl.clrAcc) |=> (acSum == $past(acSum)) && (sqSum == $past(sqSum)));
  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ctl.clrAcc) |-> sqSum >= $past(sqSum));
  p_square_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.accEn |-> !prod[SQ_W-1]);
  p_var_not_neg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.finish |-> sqQuo >= magSq);
  p_strobe_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    statsValid |=> !statsValid);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !statsValid |-> $stable(dcMean) && $stable(acMean) && $stable(acVar));

endmodule

// File: rtl/dct_stats_unit.sv
module dct_stats_unit
  import dct_stats_pkg::*;
#(
  parameter int COEF_W     = 12,
  parameter int MAX_BLOCKS = 4096,
  parameter int BLK_DIM    = 8,
  localparam int NB_W      = $clog2(MAX_BLOCKS + 1),
  localparam int VAR_W     = 2 * COEF_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     frameStart,
  input  logic [NB_W-1:0]          numBlocks,
  input  logic                     blockStart,
  input  logic                     inValid,
  input  logic signed [COEF_W-1:0] coefIn,
  output logic                     statsValid,
  output logic signed [COEF_W-1:0] dcMean,
  output logic signed [COEF_W-1:0] acMean,
  output logic [VAR_W-1:0]         acVar
);

  localparam int COEF_PER_BLK = BLK_DIM * BLK_DIM;
  localparam int AC_PER_BLK   = COEF_PER_BLK - 1;

  ctrl_t           ctl;
  logic            divIdle;
  logic [NB_W-1:0] frameBlocks;

  dct_stats_ctrl #(.COEF_PER_BLK(COEF_PER_BLK), .NB_W(NB_W)) uCtrl (
    .clk(clk), .rst_n(rst_n), .frameStart(frameStart), .blockStart(blockStart),
    .inValid(inValid), .numBlocks(numBlocks), .divIdle(divIdle),
    .ctl(ctl), .frameBlocks(frameBlocks));

  dct_stats_dp #(.COEF_W(COEF_W), .MAX_BLOCKS(MAX_BLOCKS), .AC_PER_BLK(AC_PER_BLK)) uDp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .coefIn(coefIn), .frameBlocks(frameBlocks),
    .divIdle(divIdle), .statsValid(statsValid), .dcMean(dcMean), .acMean(acMean),
    .acVar(acVar));

endmodule

// File: tb/dct_stats_unit_test.sv
module dct_stats_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frameStart = 1'b0, blockStart = 1'b0, inValid = 1'b0;
  logic [12:0] numBlocks = '0;
  logic signed [11:0] coefIn = '0;
  logic statsValid;
  logic signed [11:0] dcMean, acMean;
  logic [23:0] acVar;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;

  // reference model state
  longint mDc, mAc, mSq, mN;
  int mPos, mBlocks;
  bit active = 0;

  dct_stats_unit uut (.clk(clk), .rst_n(rst_n), .frameStart(frameStart),
    .numBlocks(numBlocks), .blockStart(blockStart), .inValid(inValid),
    .coefIn(coefIn), .statsValid(statsValid), .dcMean(dcMean),
    .acMean(acMean), .acVar(acVar));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int gen(int pat, int b, int p);
    case (pat)
      0: return (p == 0) ? 700 - b * 3 : ((b * 37 + p * 11) % 301) - 150;
      1: return (p == 0) ? -1000 - b * 9 : -((b * 13 + p * 7) % 97) - 3;
      2: return -2048;
      3: return 2047;
      default: return ((p * 97 + b * 31) % 4001) - 2000;
    endcase
  endfunction

  // drive one cycle of inputs, update the model, end at the next falling edge
  task automatic cyc(bit fs, bit bs, bit v, int c);
    int p;
    frameStart = fs; blockStart = bs; inValid = v; coefIn = 12'(c);
    if (fs) begin
      active = 1; mN = longint'(numBlocks); mDc = 0; mAc = 0; mSq = 0;
      mBlocks = 0; mPos = 0;
    end
    if (v && active) begin
      p = (bs || fs) ? 0 : mPos;
      if (p == 0) mDc += c;
      else begin mAc += c; mSq += longint'(c) * c; end
      mPos = (p == 63) ? 0 : p + 1;
      if (p == 63) begin
        mBlocks++;
        if (mBlocks == mN) active = 0;
      end
    end
    @(negedge clk);
  endtask

  task automatic sendFrame(int n, int pat, int gapEvery, bit fsWith, int prefix);
    numBlocks = 13'(n);
    if (!fsWith) cyc(1, 0, 0, 0);
    for (int k = 0; k < prefix; k++) cyc(0, k == 0, 1, gen(4, k, k));
    for (int b = 0; b < n; b++) begin
      for (int p = 0; p < 64; p++) begin
        cyc(fsWith && b == 0 && p == 0, p == 0, 1, gen(pat, b, p));
        if (fsWith && b == 0 && p == 0) numBlocks = 13'(n + 4);
        if (gapEvery != 0 && (p % gapEvery) == gapEvery - 1)
          cyc(0, (p % 3) == 0, 0, gen(4, b, p));
      end
    end
  endtask

  task automatic waitResult(string tag, bit junk);
    longint eDc, eAc, eVar;
    int n = 0;
    while (!statsValid && n < 400) begin
      cyc(0, junk && (n % 2 == 0), junk, gen(4, n, n));
      n++;
    end
    check({tag, " R7 strobe seen"}, statsValid, 1);
    eDc  = mDc / mN;
    eAc  = mAc / (63 * mN);
    eVar = mSq / (63 * mN) - eAc * eAc;
    check({tag, " R3 dcMean"}, dcMean, eDc);
    check({tag, " R4 acMean"}, acMean, eAc);
    check({tag, " R5 acVar"}, acVar, eVar);
    cyc(0, 0, 0, 0);
    check({tag, " R7 strobe one cycle"}, statsValid, 0);
  endtask

  task automatic testReset();
    check("R1 statsValid after reset", statsValid, 0);
    check("R1 dcMean after reset", dcMean, 0);
    check("R1 acMean after reset", acMean, 0);
    check("R1 acVar after reset", acVar, 0);
    for (int k = 0; k < 70; k++) begin
      cyc(0, (k % 64) == 0, 1, gen(3, 0, k));
      if (statsValid) check("R1 no strobe before frame", statsValid, 0);
    end
    check("R1 outputs untouched before frame", acVar, 0);
  endtask

  task automatic testRamp();
    sendFrame(3, 0, 0, 0, 0);
    waitResult("ramp R2", 0);
  endtask

  task automatic testNegative();
    sendFrame(5, 1, 0, 0, 0);
    waitResult("negative R2", 0);
  endtask

  task automatic testGaps();
    sendFrame(2, 0, 5, 0, 0);
    waitResult("gaps R6", 0);
  endtask

  task automatic testRealign();
    sendFrame(2, 1, 0, 0, 10);
    waitResult("realign R10", 0);
  endtask

  task automatic testIgnored();
    logic signed [11:0] d0, a0;
    logic [23:0] v0;
    sendFrame(2, 0, 0, 0, 0);
    waitResult("busy-input R9", 1);
    d0 = dcMean; a0 = acMean; v0 = acVar;
    for (int k = 0; k < 140; k++) begin
      cyc(0, (k % 64) == 0, 1, gen(3, 0, k));
      if (statsValid) check("R9 no strobe while idle", statsValid, 0);
    end
    check("R9 dcMean held while idle", dcMean, d0);
    check("R9 acMean held while idle", acMean, a0);
    check("R9 acVar held while idle", acVar, v0);
    sendFrame(1, 1, 0, 1, 0);
    waitResult("frame-start-data R8", 0);
  endtask

  task automatic testExtreme();
    sendFrame(1500, 2, 0, 0, 0);
    waitResult("min R11", 0);
    check("R11 variance zero at -2048", acVar, 0);
    sendFrame(300, 3, 0, 0, 0);
    waitResult("max R11", 0);
    check("R11 mean at 2047", acMean, 2047);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testRamp();
    testNegative();
    testGaps();
    testRealign();
    testIgnored();
    testExtreme();
    finishRun();
  end

endmodule